// File: doc/BRIEF.md
# Serial display command engine

This block sends command sequences to a small display controller over a four-wire serial link with a separate data/command select pin. A request carries an opcode, a byte count and a pixel flag. For a write, the engine shifts the opcode with the select pin low and then streams the parameter bytes with the pin high. It pulls each parameter byte from the host one at a time through a take strobe. Chip select stays asserted for the whole sequence and is released for a short gap between requests.

Opcodes in a fixed set of read commands take a receive path instead. The whole exchange runs at a reduced serial rate, and the select pin stays low. The received bytes come out on a strobe, one byte per strobe. Two of the read opcodes return data that starts one bit late. For these the engine clocks in one extra byte and shifts the stream left by one bit before output. The serial rate is chosen per phase from three rates, all derived from the system clock and the configured maximum.

Top module: `sdc_engine`

## Requirements
- R1: The select pin `dc` is low at every rising SCLK of the opcode byte. It is high at every rising SCLK of a write's parameter bytes.
- R2: A write with a count of 0 produces exactly 8 SCLK rising edges, and chip select then rises.
- R3: The opcode byte and every parameter phase run at the command rate, which is the lower of 10 MHz and the maximum. The exception is a pixel write whose count is above 64: its parameter phase runs at the maximum rate. Each SCLK high and low time equals that rate's half period.
- R4: A read runs entirely at the read rate, which is the lower of 2 MHz and half the maximum. `dc` stays low for the whole frame.
- R5: A read request with a count of 0 is rejected. `req_err` pulses for one cycle and chip select stays high.
- R6: A request for opcode 0x04 or 0x09 with a count other than 3 or 4 is rejected in the same way.
- R7: For opcodes 0x04 and 0x09 the engine clocks in count+1 bytes b0..bN. Output byte i is {b(i)[6:0], b(i+1)[7]}.
- R8: Other read opcodes (0x06–0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1, 0xA8) return the count received bytes unchanged.
- R9: Any opcode outside the read set, such as 0x05 or 0x36, follows the write path and produces no read strobes.
- R10: Chip select is high out of reset and whenever the engine is idle, with SCLK low. Between two frames it stays high for at least CS_GAP cycles. `req_ready` is high only when the engine is idle.
- R11: `rd_valid` is a one-cycle pulse. A read produces exactly count pulses.
- R12: Bytes are shifted most significant bit first. MOSI changes only while SCLK is low. `par_take` pulses once per parameter byte, and `par_data` is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted this cycle |
| req_opcode | input | 8 | Command opcode |
| req_count | input | LEN_W | Parameter count or read length |
| req_pixel | input | 1 | Request is a pixel write |
| par_data | input | 8 | Current parameter byte |
| par_take | output | 1 | par_data is consumed this cycle |
| req_err | output | 1 | Rejected read request pulse |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |

## Verification
A byte that finishes and the next byte's launch share one clock edge. This happens at the step from the opcode to the first parameter or receive byte, where the rate and `dc` may also change. The bench measures every SCLK half period against the rate its own model expects for that bit, so an extra idle cycle or a rate applied one byte late or early is counted. A rejected request may meet the idle state's readiness in the same cycle, and the bench judges it by the error pulse together with the absence of any chip-select frame.

// File: rtl/sdc_pkg.sv
// Shared types and opcode decode for the serial display command engine.
// Assumes 8-bit opcodes; the read set is fixed.
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_PAR,
        ST_RD,
        ST_GAP
    } sdc_state_e;

    typedef enum logic [1:0] {
        RATE_CMD,
        RATE_FAST,
        RATE_READ
    } sdc_rate_e;

    localparam logic [7:0] OP_IDENT  = 8'h04;
    localparam logic [7:0] OP_STATUS = 8'h09;

    // True for opcodes that return data from the display.
    function automatic logic is_read_op(input logic [7:0] op);
        logic hit;
        case (op)
            8'h04, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C,
            8'h0D, 8'h0E, 8'h0F, 8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54,
            8'h56, 8'h5F, 8'hA1, 8'hA8: hit = 1'b1;
            default:                    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // True for reads whose reply starts with one dummy bit.
    function automatic logic has_lead_bit(input logic [7:0] op);
        return (op == OP_IDENT) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/sdc_rate_sel.sv
// Serial clock rate selector.
// Computes the half period, in system clocks, for each of three serial
// rates and returns the selected one. Assumes SYS_HZ >= 2 * MAX_SCLK_HZ.
module sdc_rate_sel
    import sdc_pkg::*;
#(
    parameter int SYS_HZ      = 100_000_000,
    parameter int MAX_SCLK_HZ = 25_000_000,
    parameter int CMD_CAP_HZ  = 10_000_000,
    parameter int READ_CAP_HZ = 2_000_000,
    parameter int HALF_W      = 26
) (
    input  sdc_rate_e         rate,
    output logic [HALF_W-1:0] half
);
    localparam int CMD_HZ  = (CMD_CAP_HZ < MAX_SCLK_HZ) ? CMD_CAP_HZ : MAX_SCLK_HZ;
    localparam int RD_HZ   = (READ_CAP_HZ < MAX_SCLK_HZ / 2) ? READ_CAP_HZ : MAX_SCLK_HZ / 2;
    localparam int FAST_HC = (SYS_HZ + 2 * MAX_SCLK_HZ - 1) / (2 * MAX_SCLK_HZ);
    localparam int CMD_HC  = (SYS_HZ + 2 * CMD_HZ - 1) / (2 * CMD_HZ);
    localparam int RD_HC   = (SYS_HZ + 2 * RD_HZ - 1) / (2 * RD_HZ);
    localparam int FAST_H  = (FAST_HC < 1) ? 1 : FAST_HC;
    localparam int CMD_H   = (CMD_HC < 1) ? 1 : CMD_HC;
    localparam int RD_H    = (RD_HC < 1) ? 1 : RD_HC;

    // Pick the half period for the requested rate.
    always_comb begin
        case (rate)
            RATE_FAST: half = HALF_W'(FAST_H);
            RATE_READ: half = HALF_W'(RD_H);
            default:   half = HALF_W'(CMD_H);
        endcase
    end

endmodule

// File: rtl/sdc_shifter.sv
// One-byte serial shifter, SPI mode 0.
// A start loads a byte and its half period. MOSI updates while SCLK is low,
// and MISO is sampled as SCLK rises. byte_done is high in the cycle whose
// edge brings the last falling SCLK, so a new start at that edge follows
// with no idle cycle.
module sdc_shifter #(
    parameter int HALF_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        tx_byte,
    input  logic [HALF_W-1:0] half,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              byte_done,
    output logic [7:0]        rx_byte
);
    logic [HALF_W-1:0] tick_q;
    logic [HALF_W-1:0] half_q;
    logic [7:0]        tx_q;
    logic [7:0]        rx_q;
    logic [2:0]        bit_q;
    logic              active_q;
    logic              tick_end;

    assign tick_end  = active_q && (tick_q == half_q);
    assign byte_done = tick_end && sclk && (bit_q == 3'd7);
    assign mosi      = tx_q[7];
    assign rx_byte   = rx_q;

    // Bit timing, shift-out and sample-in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_q   <= '0;
            half_q   <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_q    <= '0;
            active_q <= 1'b0;
            sclk     <= 1'b0;
        end else if (start) begin
            active_q <= 1'b1;
            tx_q     <= tx_byte;
            half_q   <= half;
            tick_q   <= HALF_W'(1);
            bit_q    <= '0;
            sclk     <= 1'b0;
        end else if (active_q) begin
            if (tick_end) begin
                tick_q <= HALF_W'(1);
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx_q <= {rx_q[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                tick_q <= tick_q + HALF_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdc_rd_align.sv
// Read byte output stage.
// In lead-bit mode it holds one byte and emits each output byte as the held
// byte shifted left by one, topped up with the next byte's MSB. It emits
// nothing for the first byte in that mode. Otherwise bytes pass through
// unchanged. The output is registered with a one-cycle strobe.
module sdc_rd_align (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       lead_bit,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    output logic [7:0] out_byte
);
    logic [7:0] held_q;
    logic       have_q;

    // Merge adjacent bytes or pass through, one strobe per output byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= '0;
            have_q    <= 1'b0;
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else if (clear) begin
            have_q    <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                if (lead_bit && !have_q) begin
                    have_q <= 1'b1;
                    held_q <= in_byte;
                end else if (lead_bit) begin
                    out_byte  <= {held_q[6:0], in_byte[7]};
                    out_valid <= 1'b1;
                    held_q    <= in_byte;
                end else begin
                    out_byte  <= in_byte;
                    out_valid <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sdc_engine.sv
// Serial display command engine.
// Accepts one request at a time and sends the opcode with dc low. A write
// then streams count parameter bytes with dc high. A read opcode instead
// receives count bytes, plus one for lead-bit opcodes, at the read rate with
// dc low. Chip select frames each request and is released for CS_GAP cycles
// afterwards. Assumes the host holds par_data valid until par_take.
module sdc_engine
    import sdc_pkg::*;
#(
    parameter int SYS_HZ         = 100_000_000,
    parameter int MAX_SCLK_HZ    = 25_000_000,
    parameter int CMD_CAP_HZ     = 10_000_000,
    parameter int READ_CAP_HZ    = 2_000_000,
    parameter int SLOW_MAX_BYTES = 64,
    parameter int LEN_W          = 16,
    parameter int CS_GAP         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_opcode,
    input  logic [LEN_W-1:0] req_count,
    input  logic             req_pixel,
    input  logic [7:0]       par_data,
    output logic             par_take,
    output logic             req_err,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    output logic             dc,
    output logic             rd_valid,
    output logic [7:0]       rd_data
);
    localparam int HALF_W = $clog2(SYS_HZ / 2 + 2);
    localparam int GAP_W  = $clog2(CS_GAP + 2);

    sdc_state_e        state_q;
    logic              read_q;
    logic              lead_q;
    logic              pixel_q;
    logic [LEN_W-1:0]  count_q;
    logic [LEN_W-1:0]  rem_q;
    logic [GAP_W-1:0]  gap_q;

    logic              in_cmd;
    logic              in_rd;
    logic              req_is_rd;
    logic              req_lead;
    logic              req_bad;
    logic              accept;
    logic              launch;
    logic              byte_done;
    logic              more;
    logic              next_byte;
    logic              sh_start;
    logic [7:0]        sh_tx;
    logic [7:0]        sh_rx;
    logic              long_pixel;
    sdc_rate_e         rate;
    logic [HALF_W-1:0] half;

    // Request decode and per-cycle control strobes.
    always_comb begin
        in_cmd     = (state_q == ST_CMD);
        in_rd      = (state_q == ST_RD);
        req_is_rd  = is_read_op(req_opcode);
        req_lead   = has_lead_bit(req_opcode);
        req_bad    = req_is_rd && ((req_count == '0) ||
                     (req_lead && (req_count != LEN_W'(3)) && (req_count != LEN_W'(4))));
        req_ready  = (state_q == ST_IDLE);
        accept     = req_ready && req_valid;
        launch     = accept && !req_bad;
        more       = (rem_q != '0);
        next_byte  = byte_done && more && (in_cmd || in_rd || (state_q == ST_PAR));
        par_take   = next_byte && !read_q;
        sh_start   = launch || next_byte;
        sh_tx      = launch ? req_opcode : (read_q ? 8'h00 : par_data);
        long_pixel = pixel_q && (count_q > LEN_W'(SLOW_MAX_BYTES));
    end

    // Rate for the byte about to start.
    always_comb begin
        if (state_q == ST_IDLE) begin
            rate = req_is_rd ? RATE_READ : RATE_CMD;
        end else if (read_q) begin
            rate = RATE_READ;
        end else if (long_pixel) begin
            rate = RATE_FAST;
        end else begin
            rate = RATE_CMD;
        end
    end

    // Frame sequencing, chip select, dc and the reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            read_q  <= 1'b0;
            lead_q  <= 1'b0;
            pixel_q <= 1'b0;
            count_q <= '0;
            rem_q   <= '0;
            gap_q   <= '0;
            cs_n    <= 1'b1;
            dc      <= 1'b0;
            req_err <= 1'b0;
        end else begin
            req_err <= accept && req_bad;
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q <= ST_CMD;
                        cs_n    <= 1'b0;
                        dc      <= 1'b0;
                        read_q  <= req_is_rd;
                        lead_q  <= req_lead;
                        pixel_q <= req_pixel;
                        count_q <= req_count;
                        rem_q   <= req_count + LEN_W'(req_lead);
                    end
                end
                ST_CMD: begin
                    if (byte_done) begin
                        if (more) begin
                            state_q <= read_q ? ST_RD : ST_PAR;
                            dc      <= !read_q;
                            rem_q   <= rem_q - LEN_W'(1);
                        end else begin
                            state_q <= ST_GAP;
                            cs_n    <= 1'b1;
                            dc      <= 1'b0;
                            gap_q   <= GAP_W'(1);
                        end
                    end
                end
                ST_PAR, ST_RD: begin
                    if (byte_done) begin
                        if (more) begin
                            rem_q <= rem_q - LEN_W'(1);
                        end else begin
                            state_q <= ST_GAP;
                            cs_n    <= 1'b1;
                            dc      <= 1'b0;
                            gap_q   <= GAP_W'(1);
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_q >= GAP_W'(CS_GAP)) begin
                        state_q <= ST_IDLE;
                    end else begin
                        gap_q <= gap_q + GAP_W'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sdc_rate_sel #(
        .SYS_HZ      (SYS_HZ),
        .MAX_SCLK_HZ (MAX_SCLK_HZ),
        .CMD_CAP_HZ  (CMD_CAP_HZ),
        .READ_CAP_HZ (READ_CAP_HZ),
        .HALF_W      (HALF_W)
    ) u_rate (
        .rate (rate),
        .half (half)
    );

    sdc_shifter #(
        .HALF_W (HALF_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sh_start),
        .tx_byte   (sh_tx),
        .half      (half),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (byte_done),
        .rx_byte   (sh_rx)
    );

    sdc_rd_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (launch),
        .lead_bit  (lead_q),
        .in_valid  (byte_done && in_rd),
        .in_byte   (sh_rx),
        .out_valid (rd_valid),
        .out_byte  (rd_data)
    );

endmodule

// File: rtl/sdc_engine_chk.sv
// Protocol checker for sdc_engine, attached with bind.
// Observes ports plus the engine's opcode and receive phase flags.
module sdc_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic par_take,
    input logic req_err,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic dc,
    input logic rd_valid,
    input logic in_cmd,
    input logic in_rd
);
    // R10
    cs_idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R10
    ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> cs_n);

    // R5
    err_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> cs_n);

    // R11
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R4
    read_dc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd |-> !dc);

    // R1
    cmd_dc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && sclk) |-> !dc);

    // R12
    take_dc_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_take |=> (dc && !cs_n));

    // R12
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

endmodule

bind sdc_engine sdc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .par_take  (par_take),
    .req_err   (req_err),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .dc        (dc),
    .rd_valid  (rd_valid),
    .in_cmd    (in_cmd),
    .in_rd     (in_rd)
);

// File: tb/sdc_engine_tb.sv
`timescale 1ns/1ps
module sdc_engine_tb;
    // Half periods at 100 MHz with a 25 MHz maximum:
    // fast 25 MHz -> 2, command 10 MHz -> 5, read min(2, 12.5) MHz -> 25.
    localparam int HF = 2;
    localparam int HC = 5;
    localparam int HR = 25;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = 8'h00;
    logic [15:0] req_count = 16'd0;
    logic        req_pixel = 1'b0;
    logic [7:0]  par_data;
    logic        par_take;
    logic        req_err;
    logic        sclk, mosi, cs_n, dc, rd_valid;
    logic        miso = 1'b0;
    logic [7:0]  rd_data;

    logic [7:0] par_mem  [0:127];
    logic [7:0] miso_mem [0:7];
    logic [7:0] mosi_got [0:127];
    logic [7:0] rd_got   [0:7];

    int checks = 0, fails = 0;
    int pidx = 0, take_cnt = 0, rd_cnt = 0, err_cnt = 0;
    int half_bad = 0, dc_bad = 0, edges = 0, run = 0, frames = 0, hi_run = 0;
    int exp_cmd_h = HC, exp_dat_h = HC;
    bit exp_dc_hi = 1'b1, pend = 1'b0, done = 1'b0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1;

    assign par_data = par_mem[pidx[6:0]];

    always #5 clk = ~clk;

    sdc_engine u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_opcode(req_opcode), .req_count(req_count), .req_pixel(req_pixel),
        .par_data(par_data), .par_take(par_take), .req_err(req_err),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Behavioural model of the serial side, compared on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(!(cs_n && sclk), "R10 sclk low while deselected", sclk, 0);
            if (pend) pidx++;
            pend = par_take;
            if (par_take) take_cnt++;
            if (rd_valid) begin
                if (rd_cnt < 8) rd_got[rd_cnt] = rd_data;
                rd_cnt++;
            end
            if (req_err) err_cnt++;
            if (prev_cs && !cs_n) begin
                chk(frames == 0 || hi_run >= GAP, "R10 chip select gap", hi_run, GAP);
                frames++;
                run = 0;
                edges = 0;
            end else if (!prev_cs) begin
                run++;
                if (sclk != prev_sclk) begin
                    int bi;
                    int eh;
                    bi = sclk ? edges : edges - 1;
                    eh = (bi < 8) ? exp_cmd_h : exp_dat_h;
                    if (run != eh) half_bad++;
                    run = 0;
                    if (sclk) begin
                        int r;
                        mosi_got[edges / 8][7 - edges % 8] = mosi;
                        if (dc != ((edges >= 8) && exp_dc_hi)) dc_bad++;
                        edges++;
                        r = edges - 8;
                        if (r >= 0 && r / 8 < 8) miso = miso_mem[r / 8][7 - r % 8];
                    end
                end
            end
            if (cs_n) hi_run++; else hi_run = 0;
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic run_cmd(input logic [7:0] op, input int cnt, input logic pix,
                           input bit is_rd, input bit dum, input int hc, input int hd,
                           input bit exp_err, input string tag);
        int nb, bad, fr0;
        logic [7:0] expb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        take_cnt = 0; rd_cnt = 0; err_cnt = 0; half_bad = 0; dc_bad = 0;
        pidx = 0; pend = 1'b0; edges = 0; miso = 1'b0;
        exp_cmd_h = hc; exp_dat_h = hd; exp_dc_hi = !is_rd; fr0 = frames;
        for (int i = 0; i < 128; i++) mosi_got[i] = 8'h00;
        req_opcode = op; req_count = 16'(cnt); req_pixel = pix; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
        if (exp_err) begin
            chk(err_cnt == 1, {tag, " reject pulse"}, err_cnt, 1);
            chk(frames == fr0, {tag, " no frame on reject"}, frames - fr0, 0);
        end else begin
            nb = 1 + cnt + (dum ? 1 : 0);
            chk(err_cnt == 0, {tag, " no reject"}, err_cnt, 0);
            chk(edges == 8 * nb, {tag, " R12 clock edges"}, edges, 8 * nb);
            bad = 0;
            if (mosi_got[0] != op) bad++;
            if (!is_rd) for (int i = 0; i < cnt; i++) if (mosi_got[i + 1] != par_mem[i]) bad++;
            chk(bad == 0, {tag, " R12 shifted bytes"}, bad, 0);
            chk(dc_bad == 0, {tag, " R1 R4 dc level"}, dc_bad, 0);
            chk(half_bad == 0, {tag, " R3 R4 sclk half periods"}, half_bad, 0);
            chk(take_cnt == (is_rd ? 0 : cnt), {tag, " R12 take count"}, take_cnt, is_rd ? 0 : cnt);
            chk(rd_cnt == (is_rd ? cnt : 0), {tag, " R11 strobe count"}, rd_cnt, is_rd ? cnt : 0);
            if (is_rd) begin
                bad = 0;
                for (int i = 0; i < cnt; i++) begin
                    expb = dum ? {miso_mem[i][6:0], miso_mem[i + 1][7]} : miso_mem[i];
                    if (rd_got[i] != expb) bad++;
                end
                chk(bad == 0, {tag, " read bytes"}, bad, 0);
            end
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < 128; i++) par_mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0 && dc == 1'b0, "R10 reset lines", {cs_n, sclk, dc}, 4);
        chk(req_ready == 1'b1 && rd_valid == 1'b0, "R10 reset handshake", {req_ready, rd_valid}, 2);

        run_cmd(8'h29, 0, 1'b0, 0, 0, HC, HC, 0, "R2 no params");
        run_cmd(8'h2A, 4, 1'b0, 0, 0, HC, HC, 0, "R1 four params");
        run_cmd(8'h2C, 70, 1'b1, 0, 0, HC, HF, 0, "R3 long pixel");
        run_cmd(8'h2C, 10, 1'b1, 0, 0, HC, HC, 0, "R3 short pixel");
        run_cmd(8'h2C, 70, 1'b0, 0, 0, HC, HC, 0, "R3 long non-pixel");
        run_cmd(8'h2C, 65, 1'b1, 0, 0, HC, HF, 0, "R3 pixel 65");
        run_cmd(8'h2C, 64, 1'b1, 0, 0, HC, HC, 0, "R3 pixel 64");

        miso_mem[0] = 8'h9C;
        run_cmd(8'h0A, 1, 1'b0, 1, 0, HR, HR, 0, "R8 R4 power read");
        miso_mem[0] = 8'hA5; miso_mem[1] = 8'h3C; miso_mem[2] = 8'hF0; miso_mem[3] = 8'h81;
        run_cmd(8'h04, 3, 1'b0, 1, 1, HR, HR, 0, "R7 ident read");
        miso_mem[0] = 8'h5A; miso_mem[1] = 8'hC3; miso_mem[2] = 8'h0F; miso_mem[3] = 8'h7E;
        miso_mem[4] = 8'h99;
        run_cmd(8'h09, 4, 1'b0, 1, 1, HR, HR, 0, "R7 status read");
        run_cmd(8'h04, 2, 1'b0, 1, 1, HR, HR, 1, "R6 ident short");
        run_cmd(8'h09, 5, 1'b0, 1, 1, HR, HR, 1, "R6 status long");
        run_cmd(8'h0A, 0, 1'b0, 1, 0, HR, HR, 1, "R5 empty read");
        miso_mem[0] = 8'hE1; miso_mem[1] = 8'h1E;
        run_cmd(8'h2E, 2, 1'b0, 1, 0, HR, HR, 0, "R8 memory read");
        run_cmd(8'h05, 1, 1'b0, 0, 0, HC, HC, 0, "R9 opcode 05");
        run_cmd(8'h36, 2, 1'b0, 0, 0, HC, HC, 0, "R9 opcode 36");
        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule